// File: doc/BRIEF.md
# Timer Interrupt Backlog Tracker

This block sits between a periodic timer and one interrupt line. Each timer expiry adds one to a backlog of undelivered interrupts. The block sends a fixed-length interrupt pulse only when the backlog is nonzero and the previous pulse has been acknowledged. An acknowledge takes one entry off the backlog and allows the next delivery. Expiries that arrive while software is slow are therefore kept and delivered later, one handshake at a time, rather than merged.

Unmasking the interrupt or reloading the timer throws the backlog away and re-arms delivery. The counter saturates at its maximum value instead of wrapping. A tick and an acknowledge that arrive in the same cycle leave the backlog unchanged. Reset is asynchronous and active-low. Its release is synchronised inside the block.

Top module: `tmr_irq_backlog`

## Requirements
- R1: Reset state. While rst_n is low, and after its release, irq_o is 0 and pending_o is 0. The delivery permission starts granted, so the first tick after reset produces a pulse with no acknowledge needed.
- R2: A cycle with tick_i=1, ack_i=0, unmask_i=0 and reload_i=0 adds one to the backlog. pending_o reads 1 from the clock edge that samples the tick.
- R3: The backlog is CNT_W bits wide (default 8) and saturates at 2^CNT_W-1 (255). After 300 ticks with no acknowledge, exactly 255 acknowledges bring pending_o back to 0.
- R4: A lone acknowledge (ack_i=1, tick_i=0) removes one entry from the backlog. When the backlog is already zero it has no effect, and a later single tick followed by a single acknowledge still drains it to zero.
- R5: When tick_i and ack_i are both 1 in one cycle and there is no clear, the backlog stays unchanged. This holds whether the backlog is zero or nonzero.
- R6: A pulse starts only when three conditions hold: the backlog is nonzero, delivery permission is granted, and irq_o is low. irq_o rises on the clock edge after the edge that made the backlog nonzero. Starting a pulse withdraws the permission.
- R7: Each pulse keeps irq_o high for exactly PULSE_LEN consecutive cycles (default 2), and then irq_o returns to 0 for at least one cycle.
- R8: After a pulse, no further pulse starts until ack_i, unmask_i or reload_i has been seen. Without any of these, the backlog stays pending and irq_o stays low.
- R9: unmask_i=1 empties the backlog and grants delivery permission. It wins over a tick or acknowledge in the same cycle. A pulse already on the line runs to its full length.
- R10: reload_i=1 has the same effect as unmask_i, with the same priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle timer expiry strobe |
| ack_i | input | 1 | One-cycle acknowledge of the delivered interrupt |
| unmask_i | input | 1 | One-cycle strobe: interrupt was unmasked |
| reload_i | input | 1 | One-cycle strobe: timer was reloaded |
| irq_o | output | 1 | Interrupt pulse |
| pending_o | output | 1 | Backlog is nonzero |

## Verification
A change to the backlog shows on pending_o one edge after the strobe is sampled. A pulse starts on irq_o one edge after the backlog first reads nonzero, which is two edges after the tick when permission is already granted. The pulse drops PULSE_LEN edges after it rises. The bench drives every input on the falling edge and steps its reference model once for each rising edge. It compares both outputs on the next falling edge, so each check samples exactly one registered step after its stimulus. Random strobe traffic is mixed with directed runs for saturation, coincident tick and acknowledge, acknowledge at zero, and each clear source.

// File: rtl/tib_pkg.sv
package tib_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2,
    OP_CLR  = 2'd3
  } backlog_op_e;

  // Clear outranks everything; a coincident tick and acknowledge cancel.
  function automatic backlog_op_e op_decode(input logic clr, input logic tick,
                                            input logic ack);
    backlog_op_e op;
    if (clr)              op = OP_CLR;
    else if (tick && ack) op = OP_HOLD;
    else if (tick)        op = OP_INC;
    else if (ack)         op = OP_DEC;
    else                  op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/tib_rst_sync.sv
module tib_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tib_backlog.sv
module tib_backlog #(
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic nonzero_o
);
  import tib_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_max, at_zero;
  backlog_op_e      op;

  always_comb begin
    at_max  = (cnt_q == CNT_MAX);
    at_zero = (cnt_q == '0);
    op      = op_decode(clr_i, tick_i, ack_i);
    unique case (op)
      OP_CLR:  cnt_d = '0;
      OP_INC:  cnt_d = at_max  ? cnt_q : cnt_q + CNT_ONE;
      OP_DEC:  cnt_d = at_zero ? cnt_q : cnt_q - CNT_ONE;
      default: cnt_d = cnt_q;
    endcase
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nonzero_o = !at_zero;
endmodule

// File: rtl/tib_inject.sv
module tib_inject #(
  parameter int PULSE_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic irq_o
);
  localparam int              PLS_W    = $clog2(PULSE_LEN + 1);
  localparam logic [PLS_W-1:0] PLS_LOAD = PLS_W'(PULSE_LEN);
  localparam logic [PLS_W-1:0] PLS_ONE  = PLS_W'(1);

  logic             perm_q, perm_d, perm_en;
  logic [PLS_W-1:0] pls_q, pls_d;
  logic             pls_en;
  logic             line_idle, fire;

  always_comb begin
    line_idle = (pls_q == '0);
    fire      = perm_q && pending_i && line_idle && !clr_i;

    if (clr_i)      perm_d = 1'b1;
    else if (fire)  perm_d = 1'b0;
    else if (ack_i) perm_d = 1'b1;
    else            perm_d = perm_q;
    perm_en = (perm_d != perm_q);

    if (fire)            pls_d = PLS_LOAD;
    else if (!line_idle) pls_d = pls_q - PLS_ONE;
    else                 pls_d = pls_q;
    pls_en = (pls_d != pls_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      perm_q <= 1'b1;
    else if (perm_en) perm_q <= perm_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pls_q <= '0;
    else if (pls_en) pls_q <= pls_d;
  end

  assign irq_o = !line_idle;
endmodule

// File: rtl/tmr_irq_backlog.sv
module tmr_irq_backlog #(
  parameter int CNT_W       = 8,
  parameter int PULSE_LEN   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ack_i,
  input  logic unmask_i,
  input  logic reload_i,
  output logic irq_o,
  output logic pending_o
);
  logic rst_int_n;
  logic clear;
  logic backlog_nz;

  assign clear = unmask_i | reload_i;

  tib_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  tib_backlog #(.CNT_W(CNT_W)) u_backlog (
    .clk_i     (clk),
    .rst_ni    (rst_int_n),
    .tick_i    (tick_i),
    .ack_i     (ack_i),
    .clr_i     (clear),
    .nonzero_o (backlog_nz)
  );

  tib_inject #(.PULSE_LEN(PULSE_LEN)) u_inject (
    .clk_i     (clk),
    .rst_ni    (rst_int_n),
    .pending_i (backlog_nz),
    .ack_i     (ack_i),
    .clr_i     (clear),
    .irq_o     (irq_o)
  );

  assign pending_o = backlog_nz;
endmodule

// File: rtl/tib_checker.sv
module tib_checker #(
  parameter int PULSE_LEN = 2
) (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic ack_i,
  input logic unmask_i,
  input logic reload_i,
  input logic irq_o,
  input logic pending_o
);
  logic irq_prev;
  logic rearmed;
  int   hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev <= 1'b0;
      rearmed  <= 1'b1;
      hi_run   <= 0;
    end else begin
      irq_prev <= irq_o;
      hi_run   <= irq_o ? hi_run + 1 : 0;
      if (ack_i || unmask_i || reload_i) rearmed <= 1'b1;
      else if (irq_o && !irq_prev)       rearmed <= 1'b0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!irq_o && !pending_o)); // R1

  AST_TICK_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ack_i && !unmask_i && !reload_i) |=> pending_o); // R2

  AST_ACK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && ack_i && !tick_i) |=> !pending_o); // R4

  AST_RISE_NEEDS_BACKLOG: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_prev) |-> $past(pending_o)); // R6

  AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (hi_run < PULSE_LEN)); // R7

  AST_ONE_PER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_prev) |-> rearmed); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_i || reload_i) |=> !pending_o); // R9
endmodule

bind tmr_irq_backlog tib_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .ack_i     (ack_i),
  .unmask_i  (unmask_i),
  .reload_i  (reload_i),
  .irq_o     (irq_o),
  .pending_o (pending_o)
);

// File: tb/sim_tmr_irq_backlog.sv
`timescale 1ns/1ps
module sim_tmr_irq_backlog;
  localparam int CNT_W   = 8;
  localparam int PLEN    = 2;
  localparam int CNT_TOP = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n, tick, ack, unmask, reload;
  logic irq, pend;

  int n_run = 0;
  int n_bad = 0;
  int m_cnt;
  bit m_perm;
  int m_pls;

  always #4 clk = ~clk;

  tmr_irq_backlog #(.CNT_W(CNT_W), .PULSE_LEN(PLEN), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ack_i(ack),
    .unmask_i(unmask), .reload_i(reload), .irq_o(irq), .pending_o(pend)
  );

  task automatic model_reset();
    m_cnt = 0; m_perm = 1'b1; m_pls = 0;
  endtask

  task automatic model_step(input bit t, input bit a, input bit u, input bit r);
    bit clr, fire;
    clr  = u | r;
    fire = m_perm && (m_cnt != 0) && (m_pls == 0) && !clr;
    if (clr)       m_perm = 1'b1;
    else if (fire) m_perm = 1'b0;
    else if (a)    m_perm = 1'b1;
    if (fire)            m_pls = PLEN;
    else if (m_pls != 0) m_pls = m_pls - 1;
    if (clr)                        m_cnt = 0;
    else if (t && a)                m_cnt = m_cnt;
    else if (t && m_cnt < CNT_TOP)  m_cnt = m_cnt + 1;
    else if (a && !t && m_cnt > 0)  m_cnt = m_cnt - 1;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit a, input bit u, input bit r, input string tag);
    tick = t; ack = a; unmask = u; reload = r;
    @(posedge clk);
    model_step(t, a, u, r);
    @(negedge clk);
    check(tag, "irq_o", int'(irq), int'(m_pls != 0));
    check(tag, "pending_o", int'(pend), int'(m_cnt != 0));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int acks, highs;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 0; ack = 0; unmask = 0; reload = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", "irq_o in reset", int'(irq), 0);
    check("R1", "pending_o in reset", int'(pend), 0);
    rst_n = 1'b1;
    idle(4, "R1");

    // R1/R2/R6/R7: first tick fires with no acknowledge; exact timing.
    cyc(1, 0, 0, 0, "R2");
    check("R2", "pending after tick", int'(pend), 1);
    check("R6", "irq not yet", int'(irq), 0);
    cyc(0, 0, 0, 0, "R6");
    check("R6", "irq rises next edge", int'(irq), 1);
    highs = 1;
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 0, 0, "R7");
      if (irq) highs++;
    end
    check("R7", "pulse length", highs, PLEN);

    // R8: backlog still 1, no ack -> silence.
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 0, "R8");
      if (irq) highs++;
    end
    check("R8", "no pulse without ack", highs, 0);
    check("R8", "still pending", int'(pend), 1);
    cyc(0, 1, 0, 0, "R4");
    check("R4", "ack drains last", int'(pend), 0);
    idle(4, "R8");

    // R4: ack at zero has no effect.
    cyc(0, 1, 0, 0, "R4");
    cyc(0, 1, 0, 0, "R4");
    check("R4", "zero stays zero", int'(pend), 0);
    cyc(1, 0, 0, 0, "R4");
    idle(4, "R4");
    cyc(0, 1, 0, 0, "R4");
    check("R4", "one tick one ack", int'(pend), 0);
    idle(4, "R4");

    // R5: coincident tick and ack, at zero and at one.
    cyc(1, 1, 0, 0, "R5");
    check("R5", "hold at zero", int'(pend), 0);
    cyc(1, 0, 0, 0, "R5");
    cyc(1, 1, 0, 0, "R5");
    cyc(1, 1, 0, 0, "R5");
    check("R5", "hold at one", int'(pend), 1);
    cyc(0, 1, 0, 0, "R5");
    check("R5", "single entry left", int'(pend), 0);
    idle(6, "R5");

    // R3: saturation.
    for (int i = 0; i < 300; i++) cyc(1, 0, 0, 0, "R3");
    acks = 0;
    while (pend && acks < 400) begin
      cyc(0, 1, 0, 0, "R3");
      acks++;
    end
    check("R3", "acks to drain saturated backlog", acks, CNT_TOP);
    idle(6, "R3");

    // R9: unmask clears and beats a coincident tick.
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R9");
    cyc(1, 0, 1, 0, "R9");
    check("R9", "unmask empties", int'(pend), 0);
    idle(4, "R9");
    cyc(1, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, "R9");
    check("R9", "permission regranted", int'(irq), 1);
    idle(6, "R9");
    cyc(0, 1, 0, 0, "R9");

    // R10: reload clears and beats a coincident ack.
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, "R10");
    cyc(0, 1, 0, 1, "R10");
    check("R10", "reload empties", int'(pend), 0);
    idle(6, "R10");
    cyc(1, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, "R10");
    check("R10", "permission regranted", int'(irq), 1);
    idle(6, "R10");

    // Random traffic against the model.
    for (int i = 0; i < 4000; i++) begin
      bit t, a, u, r;
      t = ($urandom % 4) == 0;
      a = ($urandom % 3) == 0;
      u = ($urandom % 64) == 0;
      r = ($urandom % 64) == 0;
      cyc(t, a, u, r, "R6");
    end
    for (int i = 0; i < 1500; i++) cyc(($urandom % 2) == 0, ($urandom % 8) == 0, 0, 0, "R3");
    idle(8, "R7");

    summary();
    $finish;
  end
endmodule